// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline Datapath

This block is a small in-order processor pipeline for a machine with 16-bit instruction words. Each instruction passes through four stages in turn: fetch, operand read with effective-address formation, ALU work or data-memory access, and register write-back. Clocked registers between the stages carry the decoded instruction fields, the effective address and the operand values forward, so four instructions are in flight at once. Once the pipeline is full, one instruction finishes every cycle.

The block drives a halfword instruction-memory read port whose data returns in the same cycle. It also drives a single-cycle data-memory port that reads and writes 32-bit words. A 16-entry register file lives inside the block. It is read in the second stage and written at the clock edge that ends the fourth stage, and the write-back is shown on a set of output ports. The block has no interlocks and no forwarding. Software must space dependent instructions at least three slots apart, or it reads the old register value. Register number zero is special when read. As an address base it gives the current fetch PC, and as a data operand it gives the constant zero.

Top module: `pipe4_core`

## Requirements
- R1: The fetch address is 0 in the first cycle after reset and grows by 2 every cycle after that. The word present on the instruction port in a cycle is taken as that cycle's instruction.
- R2: An instruction word is laid out as opcode [15:12], destination rd [11:8], index/source rx [7:4] and immediate [3:0]. Opcode 0 is a no-op, 1 is load, 2 is store and 3 is add-immediate. Every other opcode acts as a no-op: it makes no store and no write-back.
- R3: An instruction fetched in cycle n drives its store onto the data port in cycle n+2. It shows its write-back on the write-back port in cycle n+3, and the register file takes that value at the clock edge that ends cycle n+3.
- R4: For a load or store whose rx is 0, the effective address is the fetch PC held during the instruction's second stage, which is the instruction's own address plus 2.
- R5: For a load or store whose rx is not 0, the effective address is the contents of register rx. A load writes the data word at that address into register rd.
- R6: A store writes the contents of register rd to the effective address. When rd is 0, the value stored is 0.
- R7: An add-immediate writes register rd plus the zero-extended 4-bit immediate into rd. When rd is 0, the operand is read as 0.
- R8: A write-back that targets register 0 is discarded. The write-back enable stays low, and register 0 keeps reading as zero.
- R9: An instruction that reads a register written by the instruction directly before it gets the old value.
- R10: An instruction that reads a register written by the instruction two slots before it also gets the old value. Its read happens in the same cycle as that write.
- R11: An instruction three or more slots after a writer sees the written value.
- R12: Synchronous reset clears the fetch PC and all registers and fills every stage with no-ops. No write-back occurs in the first three cycles after reset, and no store occurs in the first two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Fetch PC, byte address of the halfword to read |
| imem_data | input | 16 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Data-memory effective address |
| dmem_we | output | 1 | Data-memory write strobe, taken at the clock edge |
| dmem_wdata | output | 32 | Data-memory write data |
| dmem_rdata | input | 32 | Data-memory read data for dmem_addr, valid in the same cycle |
| wb_en | output | 1 | Register write-back happens at the end of this cycle |
| wb_reg | output | 4 | Destination register of the write-back |
| wb_data | output | 32 | Value written back |

## Verification
The event of most interest is a register-file write and an operand read of the same register falling in the same cycle. This happens when an add-immediate is followed two slots later by a reader of the same register. The second case that can coincide is a store in stage 3 with a load in the slot right after it. The program places writers at one, two and three slots before their readers, and places a load directly after a store to the same address. The expected write-back and store values come from a reference model that lets a read see only the writes of instructions at least three slots older. The bench compares the model with the ports on every cycle, so a design that forwards values or sees a write early gives the wrong value.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADDI  = 4'd3
  } opc_e;

  localparam logic [15:0] NOP_WORD = 16'h0000;

  function automatic logic [3:0] fld_op(input logic [15:0] w);
    return w[15:12];
  endfunction
  function automatic logic [3:0] fld_rd(input logic [15:0] w);
    return w[11:8];
  endfunction
  function automatic logic [3:0] fld_rx(input logic [15:0] w);
    return w[7:4];
  endfunction
  function automatic logic [3:0] fld_imm(input logic [15:0] w);
    return w[3:0];
  endfunction

  function automatic logic is_mem(input logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction
  function automatic logic writes_rf(input logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_ADDI);
  endfunction
endpackage

// File: rtl/p4_fetch.sv
module p4_fetch
  import pipe4_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [15:0]    imem_data,
  output logic [PCW-1:0] pc,
  output logic [15:0]    if_ir
);
  localparam logic [PCW-1:0] STEP = PCW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      if_ir <= NOP_WORD;
    end else begin
      pc    <= pc + STEP;
      if_ir <= imem_data;
    end
  end

  // R1: the fetch PC advances by one halfword each cycle
  a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(pc) + STEP);
endmodule

// File: rtl/p4_regfile.sv
module p4_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);
  localparam int NREG = 1 << AW;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  // reads return the value before any write at the coming edge
  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  // R3: a write-back lands at the edge that ends its cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && (waddr != '0)) |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/p4_operand.sv
module p4_operand
  import pipe4_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PCW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     if_ir,
  input  logic [PCW-1:0]  fetch_pc,
  output logic [3:0]      raddr_a,
  input  logic [XLEN-1:0] rdata_a,
  output logic [3:0]      raddr_b,
  input  logic [XLEN-1:0] rdata_b,
  output logic [3:0]      of_op,
  output logic [3:0]      of_rd,
  output logic [3:0]      of_imm,
  output logic [XLEN-1:0] of_ea,
  output logic [XLEN-1:0] of_op1
);
  logic [3:0]      op, rd, rx;
  logic [XLEN-1:0] base, ea_n, op1_n;

  always_comb begin
    op      = fld_op(if_ir);
    rd      = fld_rd(if_ir);
    rx      = fld_rx(if_ir);
    raddr_a = rx;
    raddr_b = rd;
    base    = (rx == 4'd0) ? XLEN'(fetch_pc) : rdata_a;
    ea_n    = is_mem(op) ? base : '0;
    op1_n   = (rd == 4'd0) ? '0 : rdata_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      of_op  <= OP_NOP;
      of_rd  <= '0;
      of_imm <= '0;
      of_ea  <= '0;
      of_op1 <= '0;
    end else begin
      of_op  <= op;
      of_rd  <= rd;
      of_imm <= fld_imm(if_ir);
      of_ea  <= ea_n;
      of_op1 <= op1_n;
    end
  end

  // R4: index zero selects the fetch PC as address base
  a_r4_pc_base: assert property (@(posedge clk) disable iff (rst)
    (is_mem(fld_op(if_ir)) && (fld_rx(if_ir) == 4'd0))
      |=> of_ea == XLEN'($past(fetch_pc)));

  // R7: operand register zero reads as the constant zero
  a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (fld_rd(if_ir) == 4'd0) |=> of_op1 == '0);
endmodule

// File: rtl/p4_execute.sv
module p4_execute
  import pipe4_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      of_op,
  input  logic [3:0]      of_rd,
  input  logic [3:0]      of_imm,
  input  logic [XLEN-1:0] of_ea,
  input  logic [XLEN-1:0] of_op1,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            ex_wr,
  output logic [3:0]      ex_rd,
  output logic [XLEN-1:0] ex_res
);
  function automatic logic [XLEN-1:0] sum_imm(input logic [XLEN-1:0] a,
                                               input logic [3:0] imm);
    return a + XLEN'(imm);
  endfunction

  logic [XLEN-1:0] res_n;

  always_comb begin
    dmem_addr  = of_ea;
    dmem_we    = (of_op == OP_STORE);
    dmem_wdata = of_op1;
    res_n      = (of_op == OP_LOAD) ? dmem_rdata : sum_imm(of_op1, of_imm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_wr  <= 1'b0;
      ex_rd  <= '0;
      ex_res <= '0;
    end else begin
      ex_wr  <= writes_rf(of_op) && (of_rd != 4'd0);
      ex_rd  <= of_rd;
      ex_res <= res_n;
    end
  end

  // R8: a write-back never names register zero
  a_r8_no_zero_dest: assert property (@(posedge clk) disable iff (rst)
    ex_wr |-> ex_rd != 4'd0);
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PCW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PCW-1:0]  imem_addr,
  input  logic [15:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            wb_en,
  output logic [3:0]      wb_reg,
  output logic [XLEN-1:0] wb_data
);
  logic [PCW-1:0]  pc;
  logic [15:0]     if_ir;
  logic [3:0]      ra, rb, of_op, of_rd, of_imm, ex_rd;
  logic [XLEN-1:0] rda, rdb, of_ea, of_op1, ex_res;
  logic            ex_wr;

  p4_fetch #(.PCW(PCW)) u_fetch (
    .clk(clk), .rst(rst), .imem_data(imem_data), .pc(pc), .if_ir(if_ir)
  );

  p4_regfile #(.XLEN(XLEN), .AW(4)) u_rf (
    .clk(clk), .rst(rst),
    .raddr_a(ra), .rdata_a(rda), .raddr_b(rb), .rdata_b(rdb),
    .we(ex_wr), .waddr(ex_rd), .wdata(ex_res)
  );

  p4_operand #(.XLEN(XLEN), .PCW(PCW)) u_opnd (
    .clk(clk), .rst(rst), .if_ir(if_ir), .fetch_pc(pc),
    .raddr_a(ra), .rdata_a(rda), .raddr_b(rb), .rdata_b(rdb),
    .of_op(of_op), .of_rd(of_rd), .of_imm(of_imm),
    .of_ea(of_ea), .of_op1(of_op1)
  );

  p4_execute #(.XLEN(XLEN)) u_exec (
    .clk(clk), .rst(rst),
    .of_op(of_op), .of_rd(of_rd), .of_imm(of_imm), .of_ea(of_ea), .of_op1(of_op1),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata),
    .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_res(ex_res)
  );

  assign imem_addr = pc;
  assign wb_en     = ex_wr;
  assign wb_reg    = ex_rd;
  assign wb_data   = ex_res;

  // cycles since reset, saturating once the pipeline is full
  logic [1:0] fill_cnt;
  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (fill_cnt != 2'd3) fill_cnt <= fill_cnt + 2'd1;
  end

  // R3: the last stage holds the word fetched three cycles earlier
  a_r3_four_stage: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == 2'd3) |-> ex_rd == fld_rd($past(imem_data, 3)));

  // R12: nothing retires while the pipeline fills
  a_r12_quiet_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt != 2'd3) |-> !wb_en);

  // R12: no store before the first instruction reaches stage 3
  a_r12_no_early_store: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt < 2'd2) |-> !dmem_we);
endmodule

// File: tb/pipe4_core_bench.sv
module pipe4_core_bench;
  localparam int NRUN = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_data;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata, wb_data;
  logic        dmem_we, wb_en;
  logic [3:0]  wb_reg;

  always #10 clk = ~clk;

  pipe4_core u_pipe4_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  logic [15:0] prog [64];
  string       tag  [64];
  logic [31:0] dmem [64];

  assign imem_data  = prog[imem_addr[6:1]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference results, indexed by instruction number
  logic        e_wb   [NRUN];
  logic [3:0]  e_reg  [NRUN];
  logic [31:0] e_val  [NRUN];
  logic        e_st   [NRUN];
  logic [31:0] e_sa   [NRUN];
  logic [31:0] e_sd   [NRUN];

  function automatic logic [15:0] enc(int op, int rd, int rx, int imm);
    return {4'(op), 4'(rd), 4'(rx), 4'(imm)};
  endfunction

  task automatic chk(input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // behavioural model: a read sees only writes of instructions >= 3 slots older
  task automatic build_ref();
    logic [31:0] rf [16];
    logic [31:0] mem [64];
    for (int i = 0; i < 16; i++) rf[i] = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h100 + 32'(i * 7);
    for (int n = 0; n < NRUN; n++) begin
      int op, rd, rx, imm;
      logic [31:0] base, opnd;
      if (n >= 3 && e_wb[n-3]) rf[e_reg[n-3]] = e_val[n-3];
      op = int'(prog[n][15:12]); rd = int'(prog[n][11:8]);
      rx = int'(prog[n][7:4]);   imm = int'(prog[n][3:0]);
      base = (rx == 0) ? 32'(2 * n + 2) : rf[rx];
      opnd = (rd == 0) ? 32'd0 : rf[rd];
      e_wb[n] = 0; e_reg[n] = 4'(rd); e_val[n] = 0;
      e_st[n] = 0; e_sa[n] = 0; e_sd[n] = 0;
      if (op == 1) begin
        e_wb[n] = (rd != 0); e_val[n] = mem[base % 64];
      end else if (op == 2) begin
        e_st[n] = 1; e_sa[n] = base; e_sd[n] = opnd;
        mem[base % 64] = opnd;
      end else if (op == 3) begin
        e_wb[n] = (rd != 0); e_val[n] = opnd + 32'(imm);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      prog[i] = 16'h0000; tag[i] = "R3";
      dmem[i] = 32'h100 + 32'(i * 7);
    end
    prog[0]  = enc(3, 1, 0, 5);   tag[0]  = "R7";
    prog[1]  = enc(3, 1, 0, 1);   tag[1]  = "R9";
    prog[2]  = enc(3, 1, 0, 2);   tag[2]  = "R10";
    prog[5]  = enc(3, 1, 0, 3);   tag[5]  = "R11";
    prog[6]  = enc(3, 2, 0, 4);   tag[6]  = "R7";
    prog[10] = enc(1, 3, 2, 0);   tag[10] = "R5";
    prog[11] = enc(1, 4, 0, 0);   tag[11] = "R4";
    prog[12] = enc(2, 1, 2, 0);   tag[12] = "R6";
    prog[13] = enc(1, 5, 2, 0);   tag[13] = "R3";
    prog[14] = enc(3, 0, 0, 7);   tag[14] = "R8";
    prog[15] = enc(2, 0, 0, 0);   tag[15] = "R6";
    prog[16] = enc(15, 6, 0, 9);  tag[16] = "R2";
    prog[17] = enc(7, 6, 0, 2);   tag[17] = "R2";
    prog[20] = enc(2, 3, 1, 0);   tag[20] = "R5";
    prog[21] = enc(3, 1, 0, 15);  tag[21] = "R7";
    prog[22] = enc(2, 1, 0, 0);   tag[22] = "R9";
    prog[23] = enc(3, 7, 0, 1);   tag[23] = "R7";
    prog[25] = enc(3, 7, 0, 2);   tag[25] = "R10";
    prog[26] = enc(3, 7, 0, 4);   tag[26] = "R11";
    build_ref();

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R12", "wb_en in reset", 32'(wb_en), 0);
    chk("R12", "dmem_we in reset", 32'(dmem_we), 0);
    rst = 1'b0;
    #1;
    for (int c = 0; c < NRUN; c++) begin
      int w, s;
      chk("R1", "imem_addr", 32'(imem_addr), 32'(2 * c));
      w = c - 3;
      s = c - 2;
      if (w < 0) chk("R12", "wb_en during fill", 32'(wb_en), 0);
      else begin
        chk(tag[w], $sformatf("wb_en instr %0d", w), 32'(wb_en), 32'(e_wb[w]));
        if (e_wb[w]) begin
          chk(tag[w], $sformatf("wb_reg instr %0d", w), 32'(wb_reg), 32'(e_reg[w]));
          chk(tag[w], $sformatf("wb_data instr %0d", w), wb_data, e_val[w]);
        end
      end
      if (s < 0) chk("R12", "dmem_we during fill", 32'(dmem_we), 0);
      else begin
        chk(tag[s], $sformatf("dmem_we instr %0d", s), 32'(dmem_we), 32'(e_st[s]));
        if (e_st[s]) begin
          chk(tag[s], $sformatf("dmem_addr instr %0d", s), dmem_addr, e_sa[s]);
          chk(tag[s], $sformatf("dmem_wdata instr %0d", s), dmem_wdata, e_sd[s]);
        end
      end
      @(negedge clk); #1;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule